// File: doc/BRIEF.md
# Latched Byte-Scan Readout with Cascade

This block takes a snapshot of a wide count word into a holding register and then reads it out one byte at a time on a narrow shared bus. An active-low load strobe captures the word and rewinds the readout to the least significant byte. Each falling edge of an external scan strobe steps the readout to the next, more significant byte. The bus is only marked as driven while the scan strobe is high, the active-low enable is asserted, and bytes remain to be read.

When the readout steps past the last byte, it parks in a terminal position and turns the bus off. It also drops its cascade output, which feeds the active-low enable of the next instance. Several instances share the scan and load strobes and chain their cascade outputs to enables. Their bytes then appear on one bus in order, with one driver at a time. The drive-enable output stands in for three-state drivers. The load, scan and enable inputs pass through two-stage synchronizers into the system clock. The count word is assumed to be synchronous to that clock.

Top module: `byte_scan_readout`

## Requirements
- R1: While the synchronized load strobe is low, the holding register copies `cnt_i` on every clock, and the readout position is set to position 1.
- R2: With load high and enable low, each falling edge of the synchronized scan strobe advances the position by exactly one.
- R3: Positions 1 to 4 put bytes 0 to 3 of the held word on `bus_o`, where byte k is bits [8k+7:8k].
- R4: Position 5 is terminal. It stays until the next load, and no scan edge leaves it.
- R5: `drive_o` is 1 only while scan is high, enable is low and the position is not 5. In particular it is 0 whenever scan is low.
- R6: `casc_o` is high except in position 5. It falls on entering position 5 and rises again on the next load.
- R7: While enable is high, scan edges do not move the position and `drive_o` stays 0.
- R8: While load is high, the held word does not change, whatever `cnt_i` does.
- R9: A scan falling edge in a cycle where load is low has no effect. The position is still 1 after load is released.
- R10: In a chain of three instances sharing scan and load, with each cascade output driving the next enable, twelve scan pulses show the twelve bytes in order. Exactly one instance drives during each pulse, and none drives on a thirteenth pulse.
- R11: After `rst_n`, the held word is zero, the position is 1, `drive_o` is 0 and `casc_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cnt_i | input | DATA_W | Count word to be captured |
| load_n_i | input | 1 | Active-low load: capture the word and rewind the readout |
| scan_i | input | 1 | Scan strobe: a falling edge steps, a high level presents the byte |
| en_n_i | input | 1 | Active-low enable for stepping and bus drive |
| bus_o | output | BYTE_W | Byte selected by the current position |
| drive_o | output | 1 | Bus drive enable, in place of three-state drivers |
| casc_o | output | 1 | Cascade output, low in the terminal position |

## Verification
On every cycle, the assertions check the following: load forces position 1, the terminal position holds, a high enable freezes the position, the held word stays fixed while load is high, and a low cascade output never coincides with drive. Some behaviours can only be shown by the bench scenarios. These are the byte order on the bus, the hand-over between chained instances with a single driver per pulse, load taking priority over a scan edge, and enable blocking a pulse in the middle of a sequence.

// File: rtl/byte_scan_pkg.sv
package byte_scan_pkg;
  localparam int SYNC_STAGES = 2;
  // synchronizer bit order: {load_n, scan, en_n}
  localparam int SIG_LOAD = 2;
  localparam int SIG_SCAN = 1;
  localparam int SIG_EN   = 0;
  localparam logic [2:0] SIG_IDLE = 3'b101;
endpackage

// File: rtl/byte_scan_sync.sv
module byte_scan_sync #(
  parameter int         W      = 3,
  parameter int         STAGES = 2,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe_q[i] <= IDLE;
    end else begin
      pipe_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/byte_scan_seq.sv
module byte_scan_seq #(
  parameter int NB    = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_s,
  input  logic             scan_s,
  input  logic             en_s,
  output logic [SEL_W-1:0] sel_o,
  output logic             drive_o,
  output logic             casc_o
);
  localparam int ST_W = $clog2(NB + 1);
  localparam logic [ST_W-1:0] TERM = ST_W'(NB);

  logic [ST_W-1:0] pos_q, pos_d;
  logic            scan_prev_q;
  logic            scan_fall;
  logic            at_term;

  assign scan_fall = scan_prev_q & ~scan_s;
  assign at_term   = (pos_q == TERM);

  always_comb begin
    pos_d = pos_q;
    if (!load_s)
      pos_d = '0;
    else if (scan_fall && !en_s && !at_term)
      pos_d = pos_q + ST_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q       <= '0;
      scan_prev_q <= 1'b0;
    end else begin
      pos_q       <= pos_d;
      scan_prev_q <= scan_s;
    end
  end

  assign sel_o   = pos_q[SEL_W-1:0];
  assign drive_o = scan_s & ~en_s & ~at_term;
  assign casc_o  = ~at_term;

  AST_LOAD_REWINDS: assert property (@(posedge clk) disable iff (!rst_n)
    !load_s |=> pos_q == '0);                                   // R1
  AST_TERM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (load_s && pos_q == TERM) |=> pos_q == TERM);               // R4
  AST_DISABLED_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_s && en_s) |=> $stable(pos_q));                       // R7
endmodule

// File: rtl/byte_scan_hold.sv
module byte_scan_hold #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_s,
  input  logic [DATA_W-1:0] cnt_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [BYTE_W-1:0] byte_o
);
  logic [DATA_W-1:0] word_q, word_d;

  always_comb begin
    word_d = word_q;
    if (!load_s) word_d = cnt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign byte_o = word_q[sel_i*BYTE_W +: BYTE_W];

  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    load_s |=> $stable(word_q));                                // R8
endmodule

// File: rtl/byte_scan_readout.sv
module byte_scan_readout #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] cnt_i,
  input  logic              load_n_i,
  input  logic              scan_i,
  input  logic              en_n_i,
  output logic [BYTE_W-1:0] bus_o,
  output logic              drive_o,
  output logic              casc_o
);
  import byte_scan_pkg::*;

  localparam int NB    = DATA_W / BYTE_W;
  localparam int SEL_W = (NB > 1) ? $clog2(NB) : 1;

  logic [2:0]       sync_s;
  logic [SEL_W-1:0] sel;

  byte_scan_sync #(.W(3), .STAGES(SYNC_STAGES), .IDLE(SIG_IDLE)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({load_n_i, scan_i, en_n_i}),
    .q_o   (sync_s)
  );

  byte_scan_seq #(.NB(NB), .SEL_W(SEL_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_s  (sync_s[SIG_LOAD]),
    .scan_s  (sync_s[SIG_SCAN]),
    .en_s    (sync_s[SIG_EN]),
    .sel_o   (sel),
    .drive_o (drive_o),
    .casc_o  (casc_o)
  );

  byte_scan_hold #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .SEL_W(SEL_W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_s (sync_s[SIG_LOAD]),
    .cnt_i  (cnt_i),
    .sel_i  (sel),
    .byte_o (bus_o)
  );

  AST_CASC_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !casc_o |-> !drive_o);                                      // R6
endmodule

// File: tb/byte_scan_readout_tb.sv
module byte_scan_readout_tb;
  localparam int DW = 32;
  localparam int BW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_n = 1'b1, scan = 1'b0, en_n = 1'b1;
  logic [DW-1:0] cnt [3];
  logic [BW-1:0] bus [3];
  logic [2:0] drv, casc;
  logic [DW-1:0] held [3];
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  for (genvar g = 0; g < 3; g++) begin : g_dev
    logic en_in;
    if (g == 0) begin : g_first
      assign en_in = en_n;
    end else begin : g_next
      assign en_in = casc[g-1];
    end
    if (g == 0) begin : g_u
      byte_scan_readout #(.DATA_W(DW), .BYTE_W(BW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt[g]), .load_n_i(load_n),
        .scan_i(scan), .en_n_i(en_in), .bus_o(bus[g]),
        .drive_o(drv[g]), .casc_o(casc[g]));
    end else begin : g_v
      byte_scan_readout #(.DATA_W(DW), .BYTE_W(BW)) u_dev (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt[g]), .load_n_i(load_n),
        .scan_i(scan), .en_n_i(en_in), .bus_o(bus[g]),
        .drive_o(drv[g]), .casc_o(casc[g]));
    end
  end

  function automatic logic [BW-1:0] exp_byte(input logic [DW-1:0] w, input int k);
    return w[k*BW +: BW];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one scan pulse; returns driver count and shared bus value at high phase,
  // and driver count during low phase
  task automatic pulse(output int nd, output logic [BW-1:0] val, output int nd_low);
    scan = 1'b1;
    repeat (4) @(negedge clk);
    nd = $countones(drv);
    val = '0;
    for (int i = 0; i < 3; i++) if (drv[i]) val = bus[i];
    scan = 1'b0;
    repeat (6) @(negedge clk);
    nd_low = $countones(drv);
  endtask

  task automatic do_load();
    for (int i = 0; i < 3; i++) begin
      cnt[i] = $urandom();
      held[i] = cnt[i];
    end
    load_n = 1'b0;
    repeat (5) @(negedge clk);
    load_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 3; i++) cnt[i] = $urandom(); // must not disturb held word
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int nd, ndl, blk;
    logic [BW-1:0] v;
    void'($urandom(32'h5CA7_0001));
    for (int i = 0; i < 3; i++) cnt[i] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(drv == 3'b000, "R11 drive off", drv, 0);
    check(casc == 3'b111, "R11 cascade high", casc, 7);
    en_n = 1'b0;
    repeat (4) @(negedge clk);
    pulse(nd, v, ndl);
    check(nd == 1 && drv == 3'b000, "R11 single driver", nd, 1);
    check(v == 8'h00, "R11 held word zero", v, 0);

    // randomized chained readouts
    for (int r = 0; r < 24; r++) begin
      blk = (r % 3 == 0) ? int'($urandom_range(0, 3)) : -1;
      do_load();
      check(casc == 3'b111, "R6 cascade high after load", casc, 7);
      for (int k = 0; k < 12; k++) begin
        if (k == blk) begin
          en_n = 1'b1;
          repeat (3) @(negedge clk);
          pulse(nd, v, ndl);
          check(nd == 0, "R7 no drive while disabled", nd, 0);
          en_n = 1'b0;
          repeat (3) @(negedge clk);
        end
        pulse(nd, v, ndl);
        check(nd == 1, "R10 exactly one driver", nd, 1);
        check(v == exp_byte(held[k/4], k%4), "R3 byte order", v, exp_byte(held[k/4], k%4));
        check(ndl == 0, "R5 no drive with scan low", ndl, 0);
        if (k % 4 == 3) begin
          check(casc[k/4] == 1'b0, "R6 cascade low in terminal", casc[k/4], 0);
          if (k < 11) check(casc[k/4+1] == 1'b1, "R2 next still active", casc[k/4+1], 1);
        end
      end
      pulse(nd, v, ndl);
      check(nd == 0, "R4 terminal drives nothing", nd, 0);
      check(casc == 3'b000, "R4 all parked", casc, 0);
    end

    // R9 load priority over a scan edge
    do_load();
    pulse(nd, v, ndl);          // now at byte 1 of dev 0
    for (int i = 0; i < 3; i++) begin cnt[i] = $urandom(); held[i] = cnt[i]; end
    load_n = 1'b0;
    repeat (4) @(negedge clk);
    scan = 1'b1;
    repeat (4) @(negedge clk);
    scan = 1'b0;
    repeat (6) @(negedge clk);
    load_n = 1'b1;
    repeat (4) @(negedge clk);
    cnt[0] = ~held[0];
    pulse(nd, v, ndl);
    check(v == exp_byte(held[0], 0), "R9 load wins over scan edge", v, exp_byte(held[0], 0));
    pulse(nd, v, ndl);
    check(v == exp_byte(held[0], 1), "R1 R2 R8 step after load", v, exp_byte(held[0], 1));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule